// File: doc/BRIEF.md
# Separable 8x8 Forward DCT Engine

This block computes the two-dimensional forward discrete cosine transform of 8x8 pixel blocks. Pixels enter one per cycle, row by row, on a valid/ready stream. A row pass transforms each group of eight pixels with an 8-point orthonormal DCT. The row results are rounded and stored in a two-bank transpose buffer. A column pass then reads that buffer one column at a time and runs the same 8-point transform on each column. Both passes take their cosine weights from one shared coefficient ROM with two read ports.

Each block produces 64 signed coefficients, one per cycle. The first coefficient of every block carries a start flag. Because the transpose buffer has two banks, the row pass can fill one block while the column pass drains the previous one. A continuous stream is therefore processed at one pixel per cycle.

Top module: `dct8x8_2d`

## Requirements
- R1: Pixels are 8-bit unsigned and are level-shifted by subtracting 128. They are consumed in row-major order, so pixel (y, x) of a block is the transfer with index 8*y + x. Every row of a horizontal ramp block is identical, so all coefficients with vertical frequency u > 0 are exactly 0. Every column of a vertical ramp block is constant, so all coefficients with horizontal frequency v > 0 are exactly 0.
- R2: Each block yields exactly 64 outputs with `outValid` high. Output index i carries the coefficient at vertical frequency u = i mod 8 and horizontal frequency v = i / 8 (column order). `outFirst` is high with index 0 only.
- R3: Each output lies within plus or minus 1 of the real-valued orthonormal 2D DCT of the level-shifted block, F(u,v) = 0.25 c(u) c(v) sum s(y,x) cos((2y+1)u pi/16) cos((2x+1)v pi/16), where c(0) = 1/sqrt(2) and c(k) = 1 otherwise. Coefficients are 12-bit signed two's complement.
- R4: A block of constant value p gives exactly 8*(p-128) at index 0 and exactly 0 at every other index.
- R5: With `inValid` held high, N back-to-back blocks are fully output within 64*N + 100 cycles of the first transfer.
- R6: A cycle with `inValid` low transfers nothing. Gaps of any length in the input stream leave the results unchanged.
- R7: During and right after reset, `outValid` is low and `inReady` is high.
- R8: The row pass never writes a bank that still holds an unread block, and the column pass reads only a complete bank. Consecutive blocks therefore never mix. `inReady` falls only when both banks hold data, counting a bank that completes in the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Pixel on `inPixel` is valid |
| inReady | output | 1 | Block can take a pixel this cycle |
| inPixel | input | 8 | Unsigned pixel sample |
| outValid | output | 1 | `outCoef` carries a coefficient |
| outFirst | output | 1 | Marks coefficient 0 of a block |
| outCoef | output | 12 | Signed DCT coefficient |

## Verification
Assertions check the bank protocol on every cycle: no writes into a full bank, reads only from a full bank, no new row loaded before the previous row pass ends, and no transfer while both banks are full. They also check that the intermediate and final sums fit their 12-bit fields and that the start flag comes only with valid data. Numerical accuracy, exact zeros for constant and ramp blocks, the row-major input order, the column output order and sustained throughput can only be shown by the scenarios. Those scenarios compare every coefficient against a floating-point model.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
  localparam int DCT_N     = 8;
  localparam int IDX_W     = $clog2(DCT_N);
  localparam int BLK_W     = 2 * IDX_W;
  localparam int PIX_W     = 8;
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 11;
  localparam int MID_W     = 12;
  localparam int MID_FRAC  = 2;
  localparam int OUT_W     = 12;
  localparam int S1_ACC_W  = PIX_W + 1 + COEF_W + IDX_W;
  localparam int S1_SHIFT  = COEF_FRAC - MID_FRAC;
  localparam int S2_ACC_W  = MID_W + COEF_W + IDX_W;
  localparam int S2_SHIFT  = COEF_FRAC + MID_FRAC;

  typedef logic signed [COEF_W-1:0] coefRow_t [DCT_N];

  typedef struct packed {
    logic             pixTake;
    logic [IDX_W-1:0] pixIdx;
    logic             rowLoad;
    logic             s1Write;
    logic [IDX_W-1:0] s1Row;
    logic [IDX_W-1:0] s1Idx;
    logic             wrBank;
    logic             s2Valid;
    logic [IDX_W-1:0] s2Col;
    logic [IDX_W-1:0] s2Idx;
    logic             s2First;
    logic             rdBank;
  } dctStrobe_t;

  // 2048 * 0.5 * cos(m*pi/16), m = 0..8
  function automatic int cosMag(int m);
    case (m)
      0: return 1024;
      1: return 1004;
      2: return 946;
      3: return 851;
      4: return 724;
      5: return 569;
      6: return 392;
      7: return 200;
      default: return 0;
    endcase
  endfunction

  // Weight of input n for frequency k, Q.11, orthonormal scaling folded in
  function automatic logic signed [COEF_W-1:0] coefAt(int k, int n);
    int m;
    int mag;
    if (k == 0) return COEF_W'(cosMag(4));
    m = ((2 * n + 1) * k) % 32;
    if (m > 16) m = 32 - m;
    if (m > 8) mag = -cosMag(16 - m);
    else       mag = cosMag(m);
    return COEF_W'(mag);
  endfunction
endpackage

// File: rtl/dct_coef_rom.sv
`timescale 1ns/1ps
module dct_coef_rom
  import dct_pkg::*;
(
  input  logic [IDX_W-1:0] rowA,
  input  logic [IDX_W-1:0] rowB,
  output coefRow_t         coefA,
  output coefRow_t         coefB
);
  for (genvar n = 0; n < DCT_N; n++) begin : gCol
    assign coefA[n] = coefAt(int'(rowA), n);
    assign coefB[n] = coefAt(int'(rowB), n);
  end
endmodule

// File: rtl/dct_ctrl.sv
`timescale 1ns/1ps
module dct_ctrl
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output dctStrobe_t strb
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DCT_N - 1);

  logic [IDX_W-1:0] pixCnt;
  logic             s1Busy;
  logic [IDX_W-1:0] s1Idx;
  logic [IDX_W-1:0] s1Row;
  logic             wrBank;
  logic [1:0]       bankFull;
  logic             s2Busy;
  logic [BLK_W-1:0] s2Cnt;
  logic             rdBank;

  logic       pixTake, rowLoad, s1Last, blkDone, s2Last;
  logic [1:0] setFull, clrFull, fullEff;

  always_comb begin
    s1Last  = s1Busy && (s1Idx == IDX_LAST);
    blkDone = s1Last && (s1Row == IDX_LAST);
    setFull = blkDone ? (2'b01 << wrBank) : 2'b00;
    s2Last  = s2Busy && (s2Cnt == '1);
    clrFull = s2Last ? (2'b01 << rdBank) : 2'b00;
    fullEff = bankFull | setFull;
    inReady = ~&fullEff;
    pixTake = inValid && inReady;
    rowLoad = pixTake && (pixCnt == IDX_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt   <= '0;
      s1Busy   <= 1'b0;
      s1Idx    <= '0;
      s1Row    <= '0;
      wrBank   <= 1'b0;
      bankFull <= 2'b00;
      s2Busy   <= 1'b0;
      s2Cnt    <= '0;
      rdBank   <= 1'b0;
    end else begin
      if (pixTake) pixCnt <= pixCnt + 1'b1;
      if (rowLoad) begin
        s1Busy <= 1'b1;
        s1Idx  <= '0;
      end else if (s1Busy) begin
        s1Idx <= s1Idx + 1'b1;
        if (s1Last) s1Busy <= 1'b0;
      end
      if (s1Last)  s1Row  <= s1Row + 1'b1;
      if (blkDone) wrBank <= ~wrBank;
      bankFull <= (bankFull | setFull) & ~clrFull;
      if (s2Last) begin
        rdBank <= ~rdBank;
        s2Busy <= bankFull[!rdBank];
        s2Cnt  <= '0;
      end else if (s2Busy) begin
        s2Cnt <= s2Cnt + 1'b1;
      end else if (bankFull[rdBank]) begin
        s2Busy <= 1'b1;
        s2Cnt  <= '0;
      end
    end
  end

  always_comb begin
    strb.pixTake = pixTake;
    strb.pixIdx  = pixCnt;
    strb.rowLoad = rowLoad;
    strb.s1Write = s1Busy;
    strb.s1Row   = s1Row;
    strb.s1Idx   = s1Idx;
    strb.wrBank  = wrBank;
    strb.s2Valid = s2Busy;
    strb.s2Col   = s2Cnt[BLK_W-1:IDX_W];
    strb.s2Idx   = s2Cnt[IDX_W-1:0];
    strb.s2First = s2Busy && (s2Cnt == '0);
    strb.rdBank  = rdBank;
  end

  AST_WRITE_FREE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    s1Busy |-> !bankFull[wrBank]); // R8
  AST_READ_FULL_BANK: assert property (@(posedge clk) disable iff (!rstN)
    s2Busy |-> bankFull[rdBank]); // R8
  AST_ROW_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    rowLoad |-> (!s1Busy || s1Idx == IDX_LAST)); // R8
  AST_NO_TAKE_BOTH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    pixTake |-> !(bankFull[0] && bankFull[1])); // R6
endmodule

// File: rtl/dct_datapath.sv
`timescale 1ns/1ps
module dct_datapath
  import dct_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PIX_W-1:0]        inPixel,
  input  dctStrobe_t              strb,
  output logic                    outValid,
  output logic                    outFirst,
  output logic signed [OUT_W-1:0] outCoef
);
  localparam logic signed [PIX_W:0]      LEVEL   = (PIX_W+1)'(1 << (PIX_W - 1));
  localparam logic signed [S1_ACC_W-1:0] S1_HALF = S1_ACC_W'(1 << (S1_SHIFT - 1));
  localparam logic signed [S2_ACC_W-1:0] S2_HALF = S2_ACC_W'(1 << (S2_SHIFT - 1));
  localparam int MID_MAX = 2 ** (MID_W - 1) - 1;
  localparam int OUT_MAX = 2 ** (OUT_W - 1) - 1;

  coefRow_t coefS1, coefS2;

  dct_coef_rom u_rom (
    .rowA  (strb.s1Idx),
    .rowB  (strb.s2Idx),
    .coefA (coefS1),
    .coefB (coefS2)
  );

  logic signed [PIX_W:0] pixShift;
  logic signed [PIX_W:0] colReg  [DCT_N];
  logic signed [PIX_W:0] holdReg [DCT_N];

  assign pixShift = $signed({1'b0, inPixel}) - LEVEL;

  always_ff @(posedge clk) begin
    if (strb.pixTake) colReg[strb.pixIdx] <= pixShift;
    if (strb.rowLoad) begin
      for (int i = 0; i < DCT_N; i++)
        holdReg[i] <= (i == DCT_N - 1) ? pixShift : colReg[i];
    end
  end

  // Row pass: one frequency per cycle
  logic signed [S1_ACC_W-1:0] s1Acc, s1Shift;
  logic signed [MID_W-1:0]    s1Mid;

  always_comb begin
    s1Acc = '0;
    for (int n = 0; n < DCT_N; n++)
      s1Acc += S1_ACC_W'(holdReg[n]) * S1_ACC_W'(coefS1[n]);
    s1Shift = (s1Acc + S1_HALF) >>> S1_SHIFT;
    s1Mid   = s1Shift[MID_W-1:0];
  end

  // Transpose buffer, two banks
  logic signed [MID_W-1:0] tBuf [2][DCT_N][DCT_N];

  always_ff @(posedge clk) begin
    if (strb.s1Write) tBuf[strb.wrBank][strb.s1Row][strb.s1Idx] <= s1Mid;
  end

  // Column pass: one frequency of one column per cycle
  logic signed [S2_ACC_W-1:0] s2Acc, s2Shift;

  always_comb begin
    s2Acc = '0;
    for (int r = 0; r < DCT_N; r++)
      s2Acc += S2_ACC_W'(tBuf[strb.rdBank][r][strb.s2Col]) * S2_ACC_W'(coefS2[r]);
    s2Shift = (s2Acc + S2_HALF) >>> S2_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outFirst <= 1'b0;
      outCoef  <= '0;
    end else begin
      outValid <= strb.s2Valid;
      outFirst <= strb.s2Valid && strb.s2First;
      if (strb.s2Valid) outCoef <= s2Shift[OUT_W-1:0];
    end
  end

  AST_MID_FITS: assert property (@(posedge clk) disable iff (!rstN)
    strb.s1Write |-> (int'(s1Shift) <= MID_MAX && int'(s1Shift) >= -MID_MAX - 1)); // R3
  AST_OUT_FITS: assert property (@(posedge clk) disable iff (!rstN)
    strb.s2Valid |-> (int'(s2Shift) <= OUT_MAX && int'(s2Shift) >= -OUT_MAX - 1)); // R3
  AST_FIRST_HAS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> outValid); // R2
endmodule

// File: rtl/dct8x8_2d.sv
`timescale 1ns/1ps
module dct8x8_2d
  import dct_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [PIX_W-1:0]        inPixel,
  output logic                    outValid,
  output logic                    outFirst,
  output logic signed [OUT_W-1:0] outCoef
);
  dctStrobe_t strb;

  dct_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .strb    (strb)
  );

  dct_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inPixel  (inPixel),
    .strb     (strb),
    .outValid (outValid),
    .outFirst (outFirst),
    .outCoef  (outCoef)
  );
endmodule

// File: tb/dct8x8_2d_tb.sv
`timescale 1ns/1ps
module dct8x8_2d_tb;
  localparam int MAXB = 6;
  localparam int NONE = -100000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [7:0]        inPixel = '0;
  logic              outValid;
  logic              outFirst;
  logic signed [11:0] outCoef;

  int  nChk = 0;
  int  nBad = 0;
  bit  finished = 0;
  int  stim  [MAXB][64];
  real refv  [MAXB][64];
  int  exact [MAXB][64];
  int  seed  = 12345;

  always #2.5 clk = ~clk;

  dct8x8_2d u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inPixel(inPixel), .outValid(outValid), .outFirst(outFirst), .outCoef(outCoef)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input real act, input real exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0f expected=%0f", tag, what, act, exp);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 255;
  endfunction

  function automatic real refCoef(int b, int u, int v);
    real pi, acc, cu, cv;
    pi = 3.14159265358979;
    acc = 0.0;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++)
        acc += real'(stim[b][8*y+x] - 128) * $cos((2*y+1)*u*pi/16.0) * $cos((2*x+1)*v*pi/16.0);
    cu = (u == 0) ? 1.0 / $sqrt(2.0) : 1.0;
    cv = (v == 0) ? 1.0 / $sqrt(2.0) : 1.0;
    return 0.25 * cu * cv * acc;
  endfunction

  task automatic buildRef(input int nb);
    for (int b = 0; b < nb; b++)
      for (int i = 0; i < 64; i++) begin
        refv[b][i]  = refCoef(b, i % 8, i / 8);
        exact[b][i] = NONE;
      end
  endtask

  // Feed nb blocks, compare every output; gapMod > 0 drops valid every gapMod-th cycle
  task automatic runStream(input int nb, input int gapMod, input string accTag,
                           input string exTag, output int cycles);
    int inIdx, outIdx, cyc, b, i;
    bit want;
    real diff;
    inIdx = 0; outIdx = 0; cyc = 0;
    while (outIdx < nb * 64 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (outValid) begin
        b = outIdx / 64;
        i = outIdx % 64;
        chk(outFirst == (i == 0), "R2", $sformatf("start flag blk %0d idx %0d", b, i),
            real'(outFirst), real'(i == 0));
        diff = real'(outCoef) - refv[b][i];
        chk(diff <= 1.0 && diff >= -1.0, accTag, $sformatf("coef blk %0d idx %0d", b, i),
            real'(outCoef), refv[b][i]);
        if (exact[b][i] != NONE)
          chk(int'(outCoef) == exact[b][i], exTag, $sformatf("exact blk %0d idx %0d", b, i),
              real'(outCoef), real'(exact[b][i]));
        outIdx++;
      end
      want = (inIdx < nb * 64) && !(gapMod > 0 && (cyc % gapMod) == 0);
      inValid = want;
      inPixel = want ? 8'(stim[inIdx / 64][inIdx % 64]) : 8'h0;
      if (want && inReady) inIdx++;
    end
    inValid = 1'b0;
    cycles = cyc;
    chk(outIdx == nb * 64, "R2", "output count / stream watchdog",
        real'(outIdx), real'(nb * 64));
    // no stray outputs after the stream
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (outValid) outIdx++;
    end
    chk(outIdx == nb * 64, "R2", "no extra outputs", real'(outIdx), real'(nb * 64));
    chk(inReady == 1'b1, "R8", "ready high when idle", real'(inReady), 1.0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(outValid == 1'b0, "R7", "outValid in reset", real'(outValid), 0.0);
    chk(inReady == 1'b1, "R7", "inReady in reset", real'(inReady), 1.0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R7", "outValid after reset", real'(outValid), 0.0);
    chk(inReady == 1'b1, "R7", "inReady after reset", real'(inReady), 1.0);
  endtask

  task automatic testUniform();
    int lv [4] = '{0, 255, 128, 77};
    int cyc;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 64; i++) stim[b][i] = lv[b];
    buildRef(4);
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 64; i++) exact[b][i] = (i == 0) ? 8 * (lv[b] - 128) : 0;
    runStream(4, 0, "R3", "R4", cyc);
  endtask

  task automatic testRamps();
    int cyc;
    for (int i = 0; i < 64; i++) begin
      stim[0][i] = (i % 8) * 32;
      stim[1][i] = (i / 8) * 32;
    end
    buildRef(2);
    for (int i = 0; i < 64; i++) begin
      if (i % 8 != 0) exact[0][i] = 0;   // horizontal ramp: u > 0 is zero (R1)
      if (i / 8 != 0) exact[1][i] = 0;   // vertical ramp: v > 0 is zero (R1)
    end
    runStream(2, 0, "R3", "R1", cyc);
  endtask

  task automatic testStream();
    int cyc;
    for (int b = 0; b < 5; b++)
      for (int i = 0; i < 64; i++) stim[b][i] = nextRand();
    buildRef(5);
    runStream(5, 0, "R8", "R8", cyc);
    chk(cyc <= 5 * 64 + 100, "R5", "cycles for 5 blocks", real'(cyc), real'(5 * 64 + 100));
  endtask

  task automatic testGaps();
    int cyc;
    for (int b = 0; b < 3; b++)
      for (int i = 0; i < 64; i++) stim[b][i] = nextRand();
    buildRef(3);
    runStream(3, 3, "R6", "R6", cyc);
  endtask

  task automatic testPatterns();
    int cyc;
    for (int i = 0; i < 64; i++) begin
      stim[0][i] = (((i / 8) + (i % 8)) % 2 == 0) ? 160 : 96;
      stim[1][i] = ((i / 8) == (i % 8)) ? 250 : 10;
      stim[2][i] = (i * 37) % 256;
    end
    buildRef(3);
    runStream(3, 0, "R3", "R3", cyc);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testUniform();
    testRamps();
    testStream();
    testGaps();
    testPatterns();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule